// File: doc/BRIEF.md
# Carry-free radix-4 hybrid signed-digit adder

This block adds a signed-digit radix-4 operand X to a plain unsigned radix-4 operand Y and returns a signed-digit radix-4 result S. Every digit of X and S lies in the range -2 to +2. Every digit of Y lies in the range 0 to 3. The adder is purely combinational and digit-parallel. No position waits for more than its right-hand neighbour, so the logic depth stays constant whatever the operand length. The block fits into wide accumulators and digit-recurrence datapaths where a carry-propagate adder would set the critical path.

Each signed digit travels on three wires. One wire weighs -2 and the other two weigh +1 each. Each unsigned digit travels on two wires, weighing +2 and +1. Each position works in two steps:
- A full adder and a plus-plus-minus adder split the position sum into a transfer of weight 4 and an interim digit in -2..+1.
- The interim digit is then joined with the transfer arriving from the position below.

The transfer into the lowest position is zero. The transfer out of the top position leaves the block as an extra output. The result digits need no further logic: the -2 wire and the first +1 wire carry the interim digit, and the second +1 wire carries the incoming transfer.

Top module: `rh4_hybrid_adder`

## Requirements
- R1: For all inputs, value(S) + 4^DIGITS * carry_out equals value(X) + value(Y). A signed digit has value -2*neg + pa + pb. An unsigned digit has value 2*hi + lo. Digit i weighs 4^i.
- R2: s_pb[0] is always 0, because the transfer into the lowest position is zero.
- R3: For i >= 1, s_pb[i] is 1 exactly when x_i + y_i >= 2 at position i-1.
- R4: carry_out is 1 exactly when x + y >= 2 at the top position DIGITS-1.
- R5: At each position i, -2*s_neg[i] + s_pa[i] equals x_i + y_i - 4*s_t, where s_t is the transfer out of position i (1 when x_i + y_i >= 2). This interim value lies in -2..+1.
- R6: Each result digit depends only on digit i of the operands and on the transfer from position i-1. No carry runs further than one position.
- R7: Codes of X with equal digit values give identical S and carry_out wires. For example, neg=1, pa=1, pb=1 behaves exactly like the all-zero code for the digit value 0. Every one of the eight three-wire codes is legal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| x_neg | input | DIGITS | X digit wires of weight -2 |
| x_pa | input | DIGITS | X digit first wires of weight +1 |
| x_pb | input | DIGITS | X digit second wires of weight +1 |
| y_hi | input | DIGITS | Y digit wires of weight +2 |
| y_lo | input | DIGITS | Y digit wires of weight +1 |
| s_neg | output | DIGITS | S digit wires of weight -2 (interim sign part) |
| s_pa | output | DIGITS | S digit first wires of weight +1 (interim low part) |
| s_pb | output | DIGITS | S digit second wires of weight +1 (transfer from the digit below) |
| carry_out | output | 1 | Transfer of weight 4^DIGITS out of the top digit |

## Verification
The assertions assume that no input wire is X or Z. They need nothing else, since every combination of the three X wires and the two Y wires is a legal digit. The bench drives only known 0/1 values. It walks every combination of all twenty input wires of the four-digit configuration, including every redundant code of X. Each input vector is applied and allowed to settle before the outputs are compared, so the combinational checks never see a half-updated operand.

// File: rtl/rh4_pkg.sv
package rh4_pkg;
  // Default operand length in digits
  parameter int unsigned RH4_DIGITS_DEFAULT = 4;

  // Signed digit: value = -2*neg + pa + pb, range -2..+2
  typedef struct packed {
    logic neg;
    logic pa;
    logic pb;
  } rh4_sd_t;

  // Unsigned digit: value = 2*hi + lo, range 0..3
  typedef struct packed {
    logic hi;
    logic lo;
  } rh4_ud_t;
endpackage

// File: rtl/rh4_full_add.sv
module rh4_full_add (
  input  logic a_i,
  input  logic b_i,
  input  logic c_i,
  output logic sum_o,
  output logic carry_o
);
  // a + b + c = 2*carry + sum
  always_comb begin
    sum_o   = a_i ^ b_i ^ c_i;
    carry_o = (a_i & b_i) | (a_i & c_i) | (b_i & c_i);
  end
endmodule

// File: rtl/rh4_ppm_add.sv
module rh4_ppm_add (
  input  logic plus0_i,
  input  logic plus1_i,
  input  logic minus_i,
  output logic up_o,
  output logic down_o
);
  // plus0 + plus1 - minus = 2*up - down, range -1..+2
  always_comb begin
    down_o = plus0_i ^ plus1_i ^ minus_i;
    up_o   = (plus0_i & plus1_i) | (plus0_i & ~minus_i) | (plus1_i & ~minus_i);
  end
endmodule

// File: rtl/rh4_cell.sv
module rh4_cell
  import rh4_pkg::*;
(
  input  rh4_sd_t x_i,
  input  rh4_ud_t y_i,
  input  logic    t_i,
  output rh4_sd_t s_o,
  output logic    t_o
);
  logic fa_sum;
  logic fa_carry;
  logic ppm_up;
  logic ppm_down;

  // Step 1a: the three weight-1 wires
  rh4_full_add u_fa (
    .a_i     (x_i.pa),
    .b_i     (x_i.pb),
    .c_i     (y_i.lo),
    .sum_o   (fa_sum),
    .carry_o (fa_carry)
  );

  // Step 1b: the weight-2 wires give transfer (weight 4) and interim -2 wire
  rh4_ppm_add u_ppm (
    .plus0_i (y_i.hi),
    .plus1_i (fa_carry),
    .minus_i (x_i.neg),
    .up_o    (ppm_up),
    .down_o  (ppm_down)
  );

  // Step 2: join the interim digit with the incoming transfer
  always_comb begin
    t_o      = ppm_up;
    s_o.neg  = ppm_down;
    s_o.pa   = fa_sum;
    s_o.pb   = t_i;
  end
endmodule

// File: rtl/rh4_hybrid_adder.sv
module rh4_hybrid_adder
  import rh4_pkg::*;
#(
  parameter int unsigned DIGITS = RH4_DIGITS_DEFAULT
) (
  input  logic [DIGITS-1:0] x_neg,
  input  logic [DIGITS-1:0] x_pa,
  input  logic [DIGITS-1:0] x_pb,
  input  logic [DIGITS-1:0] y_hi,
  input  logic [DIGITS-1:0] y_lo,
  output logic [DIGITS-1:0] s_neg,
  output logic [DIGITS-1:0] s_pa,
  output logic [DIGITS-1:0] s_pb,
  output logic              carry_out
);
  localparam int unsigned TCHAIN = DIGITS + 1;

  logic [TCHAIN-1:0] xfer;

  assign xfer[0] = 1'b0;

  for (genvar gi = 0; gi < DIGITS; gi++) begin : g_digit
    rh4_sd_t xd;
    rh4_ud_t yd;
    rh4_sd_t sd;

    always_comb begin
      xd.neg = x_neg[gi];
      xd.pa  = x_pa[gi];
      xd.pb  = x_pb[gi];
      yd.hi  = y_hi[gi];
      yd.lo  = y_lo[gi];
    end

    rh4_cell u_cell (
      .x_i (xd),
      .y_i (yd),
      .t_i (xfer[gi]),
      .s_o (sd),
      .t_o (xfer[gi+1])
    );

    assign s_neg[gi] = sd.neg;
    assign s_pa[gi]  = sd.pa;
    assign s_pb[gi]  = sd.pb;
  end

  assign carry_out = xfer[DIGITS];
endmodule

// File: rtl/rh4_hybrid_adder_chk.sv
module rh4_hybrid_adder_chk #(
  parameter int unsigned DIGITS = 4
) (
  input logic [DIGITS-1:0] x_neg,
  input logic [DIGITS-1:0] x_pa,
  input logic [DIGITS-1:0] x_pb,
  input logic [DIGITS-1:0] y_hi,
  input logic [DIGITS-1:0] y_lo,
  input logic [DIGITS-1:0] s_neg,
  input logic [DIGITS-1:0] s_pa,
  input logic [DIGITS-1:0] s_pb,
  input logic              carry_out
);
  always_comb begin
    longint lhs;
    longint rhs;
    int     pos;
    int     prev;
    lhs = 0;
    rhs = 0;
    prev = 0;
    for (int i = 0; i < int'(DIGITS); i++) begin
      pos = -2 * int'(x_neg[i]) + int'(x_pa[i]) + int'(x_pb[i])
            + 2 * int'(y_hi[i]) + int'(y_lo[i]);
      lhs += longint'(pos) <<< (2 * i);
      rhs += longint'(-2 * int'(s_neg[i]) + int'(s_pa[i]) + int'(s_pb[i])) <<< (2 * i);
      // R5: interim digit = position sum minus 4 * outgoing transfer
      assert_interim_R5: assert (-2 * int'(s_neg[i]) + int'(s_pa[i])
                                 == pos - ((pos >= 2) ? 4 : 0));
      // R3: weight-1 transfer wire reflects the lower position
      if (i > 0) begin
        assert_transfer_R3: assert (s_pb[i] == (prev >= 2));
      end
      prev = pos;
    end
    rhs += longint'(carry_out) <<< (2 * DIGITS);
    assert_value_R1: assert (lhs == rhs);
    assert_lsd_R2: assert (s_pb[0] == 1'b0);
    assert_carry_R4: assert (carry_out == (prev >= 2));
  end
endmodule

bind rh4_hybrid_adder rh4_hybrid_adder_chk #(.DIGITS(DIGITS)) u_chk (
  .x_neg     (x_neg),
  .x_pa      (x_pa),
  .x_pb      (x_pb),
  .y_hi      (y_hi),
  .y_lo      (y_lo),
  .s_neg     (s_neg),
  .s_pa      (s_pa),
  .s_pb      (s_pb),
  .carry_out (carry_out)
);

// File: tb/rh4_hybrid_adder_tb.sv
module rh4_hybrid_adder_tb;
  localparam int unsigned W = 4;
  localparam int unsigned NVEC = 1 << (5 * W);
  localparam int unsigned WATCHDOG = 150000;

  logic clk;
  logic [W-1:0] x_neg, x_pa, x_pb, y_hi, y_lo;
  logic [W-1:0] s_neg, s_pa, s_pb;
  logic carry_out;

  int checks;
  int errors;
  int cycles;
  bit done;

  rh4_hybrid_adder #(.DIGITS(W)) u_dut (
    .x_neg     (x_neg),
    .x_pa      (x_pa),
    .x_pb      (x_pb),
    .y_hi      (y_hi),
    .y_lo      (y_lo),
    .s_neg     (s_neg),
    .s_pa      (s_pa),
    .s_pb      (s_pb),
    .carry_out (carry_out)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (!done && cycles >= int'(WATCHDOG)) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected<%0d", cycles, WATCHDOG);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    checks = 0;
    errors = 0;
    cycles = 0;
    done = 1'b0;
    x_neg = '0; x_pa = '0; x_pb = '0; y_hi = '0; y_lo = '0;
    #5;
    // Zero operands give an all-zero result (R1, R2)
    check(s_neg == '0 && s_pa == '0 && s_pb == '0 && carry_out == 1'b0,
          "R1 zero operands", longint'({s_neg, s_pa, s_pb, carry_out}), 0);

    for (int v = 0; v < int'(NVEC); v++) begin
      int     pos [W];
      int     tin;
      longint xv;
      longint yv;
      longint sv;
      bit     enc_ok;
      for (int i = 0; i < int'(W); i++) begin
        x_neg[i] = v[5*i];
        x_pa[i]  = v[5*i+1];
        x_pb[i]  = v[5*i+2];
        y_lo[i]  = v[5*i+3];
        y_hi[i]  = v[5*i+4];
      end
      #1;
      xv = 0; yv = 0; sv = 0;
      tin = 0;
      enc_ok = 1'b1;
      for (int i = 0; i < int'(W); i++) begin
        int xd;
        int yd;
        int t;
        int u;
        xd = -2 * v[5*i] + v[5*i+1] + v[5*i+2];
        yd = 2 * v[5*i+4] + v[5*i+3];
        pos[i] = xd + yd;
        t = (pos[i] >= 2) ? 1 : 0;
        u = pos[i] - 4 * t;
        xv += longint'(xd) <<< (2 * i);
        yv += longint'(yd) <<< (2 * i);
        sv += longint'(-2 * int'(s_neg[i]) + int'(s_pa[i]) + int'(s_pb[i])) <<< (2 * i);
        // R5: interim value on the -2 and first +1 wires
        check(-2 * int'(s_neg[i]) + int'(s_pa[i]) == u, "R5 interim digit",
              -2 * int'(s_neg[i]) + int'(s_pa[i]), u);
        // R3 / R2: second +1 wire carries transfer from below
        if (i == 0)
          check(s_pb[0] == 1'b0, "R2 lowest transfer", s_pb[0], 0);
        else
          check(int'(s_pb[i]) == tin, "R3 transfer wire", s_pb[i], tin);
        // R6 / R7: wires fixed by local digit sum and lower transfer only
        if (s_neg[i] != (u < 0) || int'(s_pa[i]) != (u & 1) || int'(s_pb[i]) != tin)
          enc_ok = 1'b0;
        tin = t;
      end
      check(enc_ok, "R6 R7 per-digit encoding", longint'({s_neg, s_pa, s_pb}), -1);
      check(int'(carry_out) == tin, "R4 top transfer", carry_out, tin);
      sv += longint'(carry_out) <<< (2 * W);
      check(sv == xv + yv, "R1 sum value", sv, xv + yv);
      #1;
    end

    // Redundant zero code in every digit with Y = 0 gives zero result (R7)
    x_neg = '1; x_pa = '1; x_pb = '1; y_hi = '0; y_lo = '0;
    #1;
    check(s_neg == '0 && s_pa == '0 && s_pb == '0 && carry_out == 1'b0,
          "R7 redundant zero code", longint'({s_neg, s_pa, s_pb, carry_out}), 0);
    // Largest operands: all X digits +2, all Y digits 3 (R4)
    x_neg = '0; x_pa = '1; x_pb = '1; y_hi = '1; y_lo = '1;
    #1;
    check(carry_out == 1'b1, "R4 max operands carry", carry_out, 1);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule